// File: doc/BRIEF.md
# Keyed Reset Pulse Shaper

This block sits at the output of a watchdog. It holds the single 32-bit configuration word that sets the shape of the external reset pulse. When its trigger input fires, it drives the reset pin for a programmed number of 1 MHz ticks. The pulse can be active-high or active-low, and the pin can be driven push-pull or open-drain.

Software cannot set the two configuration flags directly. Each flag is set or cleared only by writing a specific key value into the top byte of the word. The pulse-width field, by contrast, takes the low bits of every write. A divider built into the block derives the tick from the block clock. Each trigger loads the width counter and restarts the divider. A new trigger therefore always starts a full-length pulse, even when one is already running.

Top module: `rst_pulse_shaper`

## Requirements
- R1: After reset, the readback is 0x000000FF. This value means active-low polarity and open-drain drive, so the pin reads 1 and output-enable reads 0.
- R2: A write with top byte 0xA5 sets bit 31 (active-high pulse).
- R3: A write with top byte 0x5A clears bit 31 (active-low pulse).
- R4: A write with top byte 0xA8 sets bit 30 (push-pull). A write with top byte 0x8A clears bit 30 (open-drain).
- R5: A write whose top byte is any other value, zero included, leaves bits 31 and 30 unchanged.
- R6: Every write replaces bits [WIDTH_BITS-1:0] (default 20) with the written data. Bits 29 down to WIDTH_BITS are never written and keep their reset value of 0.
- R7: A trigger sampled high starts the pulse on the next cycle. The pulse lasts (width+1)*TICK_DIV clock cycles, so a width of 0 gives one tick.
- R8: While the pulse is active, the pin equals bit 31. While the pulse is idle, the pin equals the inverse of bit 31.
- R9: With bit 30 set, output-enable is 1 in every cycle.
- R10: With bit 30 clear, output-enable is 1 exactly while the pulse is active.
- R11: A trigger that arrives during a pulse restarts the full width count. The pulse then ends (width+1)*TICK_DIV cycles after the new trigger.
- R12: The width used by a pulse is the one stored when its trigger was sampled. A write during the pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Write data; the top byte carries the flag keys |
| rd_data_o | output | 32 | Current configuration word |
| trig_i | input | 1 | Reset request; starts or restarts the pulse |
| rst_pin_o | output | 1 | Reset pin value |
| rst_oe_o | output | 1 | Reset pin output-enable |

## Verification
The assertions check on every cycle that:
- flags are untouched by non-key writes;
- the width field loads on each write;
- a trigger starts the pulse and reloads the counter;
- the last tick ends the pulse;
- the output-enable follows the drive mode.

Only the bench scenarios can show the pulse length in whole cycles for each width and polarity. They also cover the length after a retrigger at a chosen point and the independence of a running pulse from a mid-pulse write. Finally, a sweep of all 256 top-byte values, each applied over a known flag state, shows that exactly four keys change the flags.

// File: rtl/rst_pulse_shaper_pkg.sv
package rst_pulse_shaper_pkg;
  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PUSHPULL = 8'hA8;
  localparam logic [7:0] KEY_OPENDRN  = 8'h8A;
  localparam int unsigned POL_BIT = 31;
  localparam int unsigned DRV_BIT = 30;

  typedef struct packed {
    logic pol_high;
    logic push_pull;
  } drv_cfg_t;

  function automatic logic is_key(input logic [7:0] b);
    return (b == KEY_POL_HIGH) || (b == KEY_POL_LOW) ||
           (b == KEY_PUSHPULL) || (b == KEY_OPENDRN);
  endfunction
endpackage

// File: rtl/rst_cfg_reg.sv
module rst_cfg_reg
  import rst_pulse_shaper_pkg::*;
#(
  parameter int unsigned WIDTH_BITS = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [31:0]           wr_data_i,
  output logic [31:0]           rd_data_o,
  output drv_cfg_t              cfg_o,
  output logic [WIDTH_BITS-1:0] width_o
);
  localparam int unsigned GAP_BITS = 30 - WIDTH_BITS;

  drv_cfg_t              flags_q;
  logic [WIDTH_BITS-1:0] width_q;
  logic [7:0]            key;

  assign key = wr_data_i[31:24];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      width_q <= WIDTH_BITS'(8'hFF);
    end else if (wr_en_i) begin
      width_q <= wr_data_i[WIDTH_BITS-1:0];
      case (key)
        KEY_POL_HIGH: flags_q.pol_high  <= 1'b1;
        KEY_POL_LOW:  flags_q.pol_high  <= 1'b0;
        KEY_PUSHPULL: flags_q.push_pull <= 1'b1;
        KEY_OPENDRN:  flags_q.push_pull <= 1'b0;
        default: ;
      endcase
    end
  end

  assign rd_data_o = {flags_q.pol_high, flags_q.push_pull, {GAP_BITS{1'b0}}, width_q};
  assign cfg_o     = flags_q;
  assign width_o   = width_q;

  // R5
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_key(wr_data_i[31:24])) |=> $stable(rd_data_o[31:30]));
  // R2
  pol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[31:24] == KEY_POL_HIGH) |=> rd_data_o[POL_BIT]);
  // R4
  drv_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[31:24] == KEY_OPENDRN) |=> !rd_data_o[DRV_BIT]);
  // R6
  width_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[WIDTH_BITS-1:0] == $past(wr_data_i[WIDTH_BITS-1:0]));
endmodule

// File: rtl/rst_tick_gen.sv
module rst_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clr_i)              pre_q <= '0;
    else if (run_i) begin
      if (pre_q == LAST)         pre_q <= '0;
      else                       pre_q <= pre_q + 1'b1;
    end
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned WIDTH_BITS = 20,
  parameter int unsigned TICK_DIV   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  trig_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic                  active_o
);
  logic                  active_q;
  logic [WIDTH_BITS-1:0] cnt_q;
  logic                  tick;

  rst_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (trig_i),
    .run_i  (active_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (trig_i) begin
      active_q <= 1'b1;
      cnt_q    <= width_i;
    end else if (tick) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  // R7
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o);
  // R7
  end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !trig_i && tick && cnt_q == '0) |=> !active_o);
  // R11
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> cnt_q == $past(width_i));
endmodule

// File: rtl/rst_pin_drv.sv
module rst_pin_drv
  import rst_pulse_shaper_pkg::*;
(
  input  logic     active_i,
  input  drv_cfg_t cfg_i,
  output logic     pin_o,
  output logic     oe_o
);
  assign pin_o = active_i ? cfg_i.pol_high : ~cfg_i.pol_high;
  assign oe_o  = cfg_i.push_pull | active_i;
endmodule

// File: rtl/rst_pulse_shaper.sv
module rst_pulse_shaper
  import rst_pulse_shaper_pkg::*;
#(
  parameter int unsigned WIDTH_BITS = 20,
  parameter int unsigned TICK_DIV   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        trig_i,
  output logic        rst_pin_o,
  output logic        rst_oe_o
);
  drv_cfg_t              cfg;
  logic [WIDTH_BITS-1:0] width;
  logic                  active;

  rst_cfg_reg #(.WIDTH_BITS(WIDTH_BITS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg),
    .width_o   (width)
  );

  rst_pulse_gen #(.WIDTH_BITS(WIDTH_BITS), .TICK_DIV(TICK_DIV)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig_i),
    .width_i  (width),
    .active_o (active)
  );

  rst_pin_drv u_drv (
    .active_i (active),
    .cfg_i    (cfg),
    .pin_o    (rst_pin_o),
    .oe_o     (rst_oe_o)
  );

  // R9
  pushpull_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.push_pull |-> rst_oe_o);
  // R10
  opendrain_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.push_pull |-> (rst_oe_o == active));
  // R8
  level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_o == (active ? rd_data_o[POL_BIT] : !rd_data_o[POL_BIT]));
endmodule

// File: tb/rst_pulse_shaper_tb.sv
module rst_pulse_shaper_tb;
  localparam int unsigned WB  = 20;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trig = 1'b0;
  logic [31:0] rd_data;
  logic        pin, oe;

  int n_chk = 0;
  int n_bad = 0;
  logic m_pol = 1'b0;
  logic m_pp  = 1'b0;
  logic [WB-1:0] m_w = WB'(8'hFF);

  always #4 clk = ~clk;

  rst_pulse_shaper #(.WIDTH_BITS(WB), .TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .trig_i(trig), .rst_pin_o(pin), .rst_oe_o(oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {m_pol, m_pp, 10'b0, m_w};
  endfunction

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    case (d[31:24])
      8'hA5: m_pol = 1'b1;
      8'h5A: m_pol = 1'b0;
      8'hA8: m_pp  = 1'b1;
      8'h8A: m_pp  = 1'b0;
      default: ;
    endcase
    m_w = d[WB-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Trigger, count active cycles; optional retrigger or write at a sample index.
  task automatic pulse(input string req, input int retrig_at, input int wr_at,
                       input logic [31:0] wr_val, input int exp_len);
    int len = 0;
    int oe_bad = 0;
    @(negedge clk);
    check("R8 idle pin", {31'b0, pin}, {31'b0, ~m_pol});
    check("R9/R10 idle oe", {31'b0, oe}, {31'b0, m_pp});
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (pin == m_pol && len < 5000) begin
      len++;
      if (oe !== 1'b1) oe_bad++;
      trig  = (len == retrig_at);
      wr_en = (len == wr_at);
      wr_data = wr_val;
      @(negedge clk);
    end
    trig = 1'b0;
    if (wr_at > 0) begin
      if (wr_val[31:24] == 8'hA5) m_pol = 1'b1;
      m_w = wr_val[WB-1:0];
    end
    wr_en = 1'b0;
    check({req, " length"}, len, exp_len);
    check("R9/R10 oe during pulse", oe_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset word", rd_data, 32'h0000_00FF);
    check("R1 idle pin/oe", {30'b0, pin, oe}, 32'h2);

    // R2 R3 R4 R5 R6: sweep every top byte over each starting flag state
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        do_write({8'h5A, 24'h0});
        do_write({8'h8A, 24'h0});
        if (s[0]) do_write({8'hA5, 24'h0});
        if (s[1]) do_write({8'hA8, 24'h0});
        do_write({b[7:0], 4'hF, 12'h0, b[7:0]});
        check("R2/R3/R4/R5/R6 key sweep", rd_data, exp_word());
      end
    end

    // R6: full width field
    do_write({8'h00, 4'hF, 20'hABCDE});
    check("R6 full width", rd_data, exp_word());

    // R7 R8 R9 R10: widths by polarity and drive
    for (int c = 0; c < 4; c++) begin
      do_write({(c[0] ? 8'hA5 : 8'h5A), 24'h0});
      do_write({(c[1] ? 8'hA8 : 8'h8A), 24'h0});
      for (int w = 0; w < 6; w++) begin
        do_write({8'h00, 24'(w)});
        pulse("R7/R8", 0, 0, 32'h0, (w + 1) * DIV);
      end
    end

    // R11: retrigger mid-pulse
    do_write({8'hA5, 24'h0});
    do_write({8'h8A, 24'd3});
    pulse("R11 retrigger", 5, 0, 32'h0, 5 + 4 * DIV);
    pulse("R11 retrigger late", 15, 0, 32'h0, 15 + 4 * DIV);

    // R12: write during pulse keeps the running length
    do_write({8'h00, 24'd2});
    pulse("R12 mid-pulse write", 0, 2, {8'h00, 24'd9}, 3 * DIV);
    check("R12 new width stored", rd_data, exp_word());
    pulse("R12 next pulse", 0, 0, 32'h0, 10 * DIV);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule